// File: doc/BRIEF.md
# Small Floating-Point Multiplier

This block multiplies two numbers held in a compact 12-bit floating-point encoding and returns their 12-bit product. Each word has a sign in bit 11, a biased exponent in bits 10:6 (bias 15) and a stored fraction in bits 5:0. The significand has a hidden leading one. The block forms the product sign and the product exponent. It multiplies the two 7-bit significands, shifts the product so that its leading one is in place, and cuts the fraction to six bits with no rounding.

Two exponent codes are reserved. Code 0 means zero and code 31 means infinity, whatever the fraction holds. Results that fall outside the normal range are forced to one of these two codes. The product of zero and infinity gives infinity and raises an invalid flag.

By default the result is registered. A valid input produces a valid output one clock later. A build-time parameter can instead make the path purely combinational.

Top module: `minifloat_mul`

## Requirements
- R1: For two finite nonzero operands, result bit 11 equals the XOR of the operand sign bits. For every special result the sign is also the XOR of the operand signs.
- R2: When the significand product (1.fa × 1.fb, read as a 14-bit integer (64+fa)(64+fb)) is below 8192, the result exponent is ea+eb−15 and the result fraction is product bits 11:6.
- R3: When that product is 8192 or above, the result exponent is ea+eb−14 and the result fraction is product bits 12:7.
- R4: A computed exponent of 31 or more gives infinity: exponent bits 11111, fraction 000000, with the XOR sign.
- R5: A computed exponent of 0 or less gives zero: exponent 00000, fraction 000000, with the XOR sign.
- R6: An operand with exponent 00000 is zero, whatever its fraction. If the other operand is not infinite, the result is signed zero and the invalid flag is 0.
- R7: An operand with exponent 11111 is infinity, whatever its fraction. If the other operand is not zero, the result is signed infinity and the invalid flag is 0.
- R8: Zero times infinity, in either operand order, returns signed infinity with the invalid flag at 1.
- R9: In registered mode, out_valid follows in_valid one cycle later. While in_valid is low, the result and the flag hold their last values. Reset clears out_valid, the result and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present |
| a_i | input | 12 | Operand A |
| b_i | input | 12 | Operand B |
| out_valid | output | 1 | Result is present |
| r_o | output | 12 | Product |
| invalid_o | output | 1 | Set for zero times infinity |

## Verification
The datapath holds no state beyond one output register, so any wrong internal value shows at r_o one cycle after the operands that caused it. A bad exponent sum or a missed normalization shift shows as a wrong exponent or fraction field in that cycle. A bad saturation test shows as a stray exponent code near 0 or 31. A fault in the capture enable shows up instead as a result that changes while in_valid is low, or as out_valid arriving in the wrong cycle.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2
    } opclass_e;
endpackage

// File: rtl/mfm_unpack.sv
module mfm_unpack
    import mfm_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 6
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output logic                  sign_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W:0]       sig_o,
    output opclass_e              cls_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    always_comb begin
        sign_o = op_i[W-1];
        exp_o  = op_i[W-2 -: EXP_W];
        sig_o  = {1'b1, op_i[FRAC_W-1:0]};
        if (exp_o == '0)
            cls_o = CLS_ZERO;
        else if (exp_o == '1)
            cls_o = CLS_INF;
        else
            cls_o = CLS_NORM;
    end
endmodule

// File: rtl/mfm_core.sv
module mfm_core
    import mfm_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 6
) (
    input  logic                  sign_a,
    input  logic                  sign_b,
    input  logic [EXP_W-1:0]      exp_a,
    input  logic [EXP_W-1:0]      exp_b,
    input  logic [FRAC_W:0]       sig_a,
    input  logic [FRAC_W:0]       sig_b,
    input  opclass_e              cls_a,
    input  opclass_e              cls_b,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  invalid_o
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int IW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam int SHIFT  = PROD_W - 1 - FRAC_W;

    logic              sign;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] norm;
    logic              carry;
    logic [IW-1:0]     exp_wide;   // two's complement intermediate
    logic              ovf;
    logic              unf;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        sign     = sign_a ^ sign_b;
        prod     = PROD_W'(sig_a) * PROD_W'(sig_b);
        carry    = prod[PROD_W-1];
        norm     = carry ? prod : (prod << 1);
        frac     = FRAC_W'(norm >> SHIFT);
        exp_wide = IW'(exp_a) + IW'(exp_b) + IW'(carry) - IW'(BIAS);
        ovf      = !exp_wide[IW-1] && (exp_wide[IW-2:0] >= (IW-1)'(EMAX));
        unf      = exp_wide[IW-1] || (exp_wide == '0);

        invalid_o = 1'b0;
        if (cls_a == CLS_INF || cls_b == CLS_INF) begin
            res_o     = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            invalid_o = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
        end else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO) begin
            res_o = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
        end else if (ovf) begin
            res_o = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (unf) begin
            res_o = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
        end else begin
            res_o = {sign, exp_wide[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/minifloat_mul.sv
module minifloat_mul
    import mfm_pkg::*;
#(
    parameter int EXP_W      = 5,
    parameter int FRAC_W     = 6,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] r_o,
    output logic                  invalid_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [1:0]        op_sign;
    logic [EXP_W-1:0]  op_exp [2];
    logic [FRAC_W:0]   op_sig [2];
    opclass_e          op_cls [2];
    logic [W-1:0]      res_c;
    logic              inv_c;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        mfm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .op_i   ((i == 0) ? a_i : b_i),
            .sign_o (op_sign[i]),
            .exp_o  (op_exp[i]),
            .sig_o  (op_sig[i]),
            .cls_o  (op_cls[i])
        );
    end

    mfm_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .sign_a    (op_sign[0]),
        .sign_b    (op_sign[1]),
        .exp_a     (op_exp[0]),
        .exp_b     (op_exp[1]),
        .sig_a     (op_sig[0]),
        .sig_b     (op_sig[1]),
        .cls_a     (op_cls[0]),
        .cls_b     (op_cls[1]),
        .res_o     (res_c),
        .invalid_o (inv_c)
    );

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         inv;
    } out_t;

    if (REGISTERED) begin : g_reg
        out_t out_d, out_q;

        always_comb begin
            out_d     = out_q;
            out_d.vld = in_valid;
            if (in_valid) begin
                out_d.res = res_c;
                out_d.inv = inv_c;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q <= '0;
            else
                out_q <= out_d;
        end

        assign out_valid = out_q.vld;
        assign r_o       = out_q.res;
        assign invalid_o = out_q.inv;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign out_valid  = in_valid;
        assign r_o        = res_c;
        assign invalid_o  = inv_c;
    end
endmodule

// File: rtl/mfm_chk.sv
module mfm_chk #(
    parameter int EXP_W      = 5,
    parameter int FRAC_W     = 6,
    parameter bit REGISTERED = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] a_i,
    input logic [EXP_W+FRAC_W:0] b_i,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] r_o,
    input logic                  invalid_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    if (REGISTERED) begin : g_props
        p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(r_o) && $stable(invalid_o)));
        p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (r_o[W-1] == $past(a_i[W-1] ^ b_i[W-1])));
        p_invalid_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
            invalid_o |-> (r_o[W-2 -: EXP_W] == '1));
        p_inf_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && r_o[W-2 -: EXP_W] == '1) |-> (r_o[FRAC_W-1:0] == '0));
        p_zero_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && r_o[W-2 -: EXP_W] == '0) |-> (r_o[FRAC_W-1:0] == '0));
    end
endmodule

bind minifloat_mul mfm_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
    .out_valid(out_valid), .r_o(r_o), .invalid_o(invalid_o)
);

// File: tb/sim_minifloat_mul.sv
module sim_minifloat_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] a = '0;
    logic [11:0] b = '0;
    logic        out_valid;
    logic [11:0] r;
    logic        inv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    minifloat_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_i(a), .b_i(b),
        .out_valid(out_valid), .r_o(r), .invalid_o(inv)
    );

    // Reference: returns {invalid, result}; req gets the requirement tag number.
    // R2/R3 normal paths, R4/R5 saturation, R6 zero operand, R7/R8 infinity.
    function automatic logic [12:0] model(input logic [11:0] x, input logic [11:0] y,
                                          output int req);
        int ea, eb, fa, fb, p, e, f;
        logic s;
        ea = int'(x[10:6]); eb = int'(y[10:6]);
        fa = int'(x[5:0]);  fb = int'(y[5:0]);
        s  = x[11] ^ y[11];
        if (ea == 31 || eb == 31) begin
            req = (ea == 0 || eb == 0) ? 8 : 7;
            return {(ea == 0 || eb == 0), s, 5'd31, 6'd0};
        end
        if (ea == 0 || eb == 0) begin
            req = 6;
            return {1'b0, s, 11'd0};
        end
        p = (64 + fa) * (64 + fb);
        e = ea + eb - 15;
        if (p >= 8192) begin
            e = e + 1; f = (p / 128) % 64; req = 3;
        end else begin
            f = (p / 64) % 64; req = 2;
        end
        if (e >= 31) begin req = 4; return {1'b0, s, 5'd31, 6'd0}; end
        if (e <= 0)  begin req = 5; return {1'b0, s, 11'd0}; end
        return {1'b0, s, 5'(e), 6'(f)};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [12:0] act, input logic [12:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [12:0] expv;
        logic [11:0] last_r;
        logic        last_inv;
        int          req;
        bit          pend;
        pend = 1'b0;
        expv = '0;
        req  = 0;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(!out_valid && r == 12'd0 && !inv, "R9 reset",
              {inv, r}, 13'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep all exponent pairs, several fractions, mixed signs.
        for (int ea = 0; ea < 32; ea++) begin
            for (int eb = 0; eb < 32; eb++) begin
                for (int ka = 0; ka < 8; ka++) begin
                    for (int kb = 0; kb < 8; kb++) begin
                        if (pend) begin
                            check(out_valid && {inv, r} == expv,
                                  $sformatf("R%0d (R1 sign)", req), {inv, r}, expv);
                        end
                        a = {1'(ea ^ kb), 5'(ea), 6'(ka * 9)};
                        b = {1'(eb + ka), 5'(eb), 6'(kb * 9)};
                        in_valid = 1'b1;
                        expv = model(a, b, req);
                        pend = 1'b1;
                        @(negedge clk);
                    end
                end
            end
        end
        check(out_valid && {inv, r} == expv, $sformatf("R%0d", req), {inv, r}, expv);

        // R9: idle inputs leave result and flag untouched
        last_r = r; last_inv = inv;
        in_valid = 1'b0;
        a = 12'h7C0; b = 12'h000;
        @(negedge clk);
        check(!out_valid && r == last_r && inv == last_inv, "R9 hold",
              {inv, r}, {last_inv, last_r});
        a = 12'h3C5; b = 12'h3C5;
        @(negedge clk);
        check(!out_valid && r == last_r && inv == last_inv, "R9 hold2",
              {inv, r}, {last_inv, last_r});

        // R8 directed, both orders, with nonzero fractions
        in_valid = 1'b1; a = 12'h03F; b = 12'hFC1;
        @(negedge clk);
        check(out_valid && {inv, r} == 13'h1FC0, "R8 zero*inf", {inv, r}, 13'h1FC0);
        a = 12'h7C1; b = 12'h001;
        @(negedge clk);
        check(out_valid && {inv, r} == 13'h17C0, "R8 inf*zero", {inv, r}, 13'h17C0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule